// File: doc/BRIEF.md
# Run-Time Depth-Selectable Queue

This block is a first-in first-out queue with room for 32 words of 32 bits. Only part of that room is usable at any one time, and a mode input and a frame-width input choose how much. A serial controller uses one copy as its outgoing queue and one as its incoming queue. Narrow frames get the full room, wide frames get less, and the compact default gets four slots. Producers and consumers talk to it over valid/ready streams. Mode, frame width, flush and the three occupancy flags are plain level pins.

Back-pressure works as follows. `in_ready` is high whenever occupancy is below the usable depth. A word is taken on a rising clock edge when `in_valid` and `in_ready` are both high. If `in_valid` is high while `in_ready` is low, the word is dropped: nothing is stored and the producer is not told. On the read side, `out_valid` is high whenever the queue holds data, and `out_data` shows the oldest word. That word is removed on an edge where `out_valid` and `out_ready` are both high. When the queue is empty, `out_data` reads zero, and asserting `out_ready` changes nothing.

A push and a pop in the same cycle are both taken, unless the queue is full (no push is taken) or empty (no pop is taken). `flush` takes priority over both streams. The mode and frame width must only change while the queue is empty.

Top module: `frame_depth_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `near_full`=0, `out_valid`=0 and `out_data`=0.
- R2: With `wide_mode`=0, the usable depth is 4 for any `frame_bits`.
- R3: With `wide_mode`=1 and `frame_bits` at most 8, the usable depth is 32.
- R4: With `wide_mode`=1 and `frame_bits` from 9 to 16, the usable depth is 16.
- R5: With `wide_mode`=1 and `frame_bits` of 17 or more, the usable depth is 8.
- R6: A word offered while occupancy equals the usable depth is dropped. Occupancy, flags and stored contents are unchanged, and the word never appears at `out_data`.
- R7: `near_full` is 1 exactly when occupancy is at least the usable depth minus one. It therefore sets at depth-1 and clears when occupancy falls below that value.
- R8: `full` is 1 exactly when occupancy equals the usable depth. A pop clears it.
- R9: `empty` clears on any accepted push. It sets when a pop removes the last word.
- R10: `out_data` always shows the oldest stored word, and words leave in the order they were accepted.
- R11: A pop request while empty leaves pointers and flags unchanged, and `out_data` stays 0. The next word pushed is the next word shown.
- R12: `flush` empties the queue in one cycle, clearing `full` and `near_full`. It overrides a push or pop in the same cycle.
- R13: A push and a pop in the same cycle, with the queue neither full nor empty, leave occupancy unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 selects the frame-width-dependent depth, 0 the 4-slot depth |
| frame_bits | input | 6 | Programmed frame width in bits |
| flush | input | 1 | Synchronous clear of all contents |
| in_valid | input | 1 | Write stream: word offered |
| in_ready | output | 1 | Write stream: room available |
| in_data | input | 32 | Write stream: word |
| out_valid | output | 1 | Read stream: word available |
| out_ready | input | 1 | Read stream: consumer takes the word |
| out_data | output | 32 | Read stream: oldest word, 0 when empty |
| full | output | 1 | Occupancy equals usable depth |
| near_full | output | 1 | Occupancy at least usable depth minus one |
| empty | output | 1 | No words held |

## Verification
A wrong count or pointer inside the queue shows at the ports within one cycle. A flag disagrees with the number of accepted pushes, `in_ready` drops at the wrong fill level, or `out_data` shows a word out of order or a word that should have been dropped. Filling the queue in every depth setting exposes a bad depth decode on the edge where `in_ready` should fall. Draining it after a dropped push, a simultaneous push and pop, or a pop on empty exposes pointer damage on the first word read back.

// File: rtl/frame_depth_fifo_pkg.sv
package frame_depth_fifo_pkg;
  localparam int unsigned FDQ_WIDTH      = 32;
  localparam int unsigned FDQ_CAP        = 32;
  localparam int unsigned FDQ_FS_W       = 6;
  localparam int unsigned FDQ_BASE_DEPTH = 4;
  localparam int unsigned FDQ_LIM_NARROW = 8;
  localparam int unsigned FDQ_LIM_MID    = 16;

  typedef enum logic [1:0] {
    DEPTH_BASE   = 2'd0,
    DEPTH_WHOLE  = 2'd1,
    DEPTH_HALF   = 2'd2,
    DEPTH_FOURTH = 2'd3
  } depth_class_e;
endpackage

// File: rtl/fdq_depth_sel.sv
module fdq_depth_sel
  import frame_depth_fifo_pkg::*;
#(
  parameter int unsigned CAP        = FDQ_CAP,
  parameter int unsigned FS_W       = FDQ_FS_W,
  parameter int unsigned BASE_DEPTH = FDQ_BASE_DEPTH,
  parameter int unsigned LIM_NARROW = FDQ_LIM_NARROW,
  parameter int unsigned LIM_MID    = FDQ_LIM_MID,
  localparam int unsigned CW        = $clog2(CAP) + 1
) (
  input  logic            wide_mode,
  input  logic [FS_W-1:0] frame_bits,
  output depth_class_e    depth_class,
  output logic [CW-1:0]   depth
);
  // Classify the setting first, then map the class to a slot count.
  always_comb begin
    if (!wide_mode)                            depth_class = DEPTH_BASE;
    else if (frame_bits <= FS_W'(LIM_NARROW))  depth_class = DEPTH_WHOLE;
    else if (frame_bits <= FS_W'(LIM_MID))     depth_class = DEPTH_HALF;
    else                                       depth_class = DEPTH_FOURTH;
  end

  always_comb begin
    unique case (depth_class)
      DEPTH_WHOLE:  depth = CW'(CAP);
      DEPTH_HALF:   depth = CW'(CAP / 2);
      DEPTH_FOURTH: depth = CW'(CAP / 4);
      default:      depth = CW'(BASE_DEPTH);
    endcase
  end
endmodule

// File: rtl/fdq_ctrl.sv
module fdq_ctrl #(
  parameter int unsigned CAP = 32,
  localparam int unsigned AW = $clog2(CAP),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] depth,
  input  logic          flush,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          empty,
  output logic          full,
  output logic          near_full
);
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q, count_nxt;
  logic          pop_ok;
  logic          empty_q, full_q, near_q;

  // A push needs room under the usable depth; a pop needs a stored word.
  assign push_ok = push_req && !full_q && !flush;
  assign pop_ok  = pop_req && !empty_q && !flush;

  always_comb begin
    if (flush) count_nxt = '0;
    else       count_nxt = count_q + CW'(push_ok) - CW'(pop_ok);
  end

  // Pointers run over the whole physical array and wrap at its size.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else if (flush) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_q + AW'(1);
      if (pop_ok)  rptr_q <= rptr_q + AW'(1);
      count_q <= count_nxt;
    end
  end

  // Flags are registered from the next occupancy.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      near_q  <= 1'b0;
    end else begin
      empty_q <= (count_nxt == '0);
      full_q  <= (count_nxt >= depth);
      near_q  <= (count_nxt >= (depth - CW'(1)));
    end
  end

  assign wr_addr   = wptr_q;
  assign rd_addr   = rptr_q;
  assign empty     = empty_q;
  assign full      = full_q;
  assign near_full = near_q;
endmodule

// File: rtl/fdq_store.sv
module fdq_store #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned CAP   = 32,
  localparam int unsigned AW   = $clog2(CAP)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  input  logic             rd_blank,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] cells [CAP];

  // One enabled register per slot.
  for (genvar g = 0; g < CAP; g++) begin : g_slot
    logic [WIDTH-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr == AW'(g))) cell_q <= wr_data;
    end
    assign cells[g] = cell_q;
  end

  // An empty queue reads as zero so stale slots never leak out.
  assign rd_data = rd_blank ? '0 : cells[rd_addr];
endmodule

// File: rtl/frame_depth_fifo.sv
module frame_depth_fifo
  import frame_depth_fifo_pkg::*;
#(
  parameter int unsigned WIDTH      = FDQ_WIDTH,
  parameter int unsigned CAP        = FDQ_CAP,
  parameter int unsigned FS_W       = FDQ_FS_W,
  parameter int unsigned BASE_DEPTH = FDQ_BASE_DEPTH,
  parameter int unsigned LIM_NARROW = FDQ_LIM_NARROW,
  parameter int unsigned LIM_MID    = FDQ_LIM_MID
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_mode,
  input  logic [FS_W-1:0]  frame_bits,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             full,
  output logic             near_full,
  output logic             empty
);
  localparam int unsigned AW = $clog2(CAP);
  localparam int unsigned CW = AW + 1;

  depth_class_e  depth_class;
  logic [CW-1:0] depth;
  logic          push_ok;
  logic [AW-1:0] wr_addr, rd_addr;

  fdq_depth_sel #(
    .CAP(CAP), .FS_W(FS_W), .BASE_DEPTH(BASE_DEPTH),
    .LIM_NARROW(LIM_NARROW), .LIM_MID(LIM_MID)
  ) u_depth (
    .wide_mode  (wide_mode),
    .frame_bits (frame_bits),
    .depth_class(depth_class),
    .depth      (depth)
  );

  fdq_ctrl #(.CAP(CAP)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .depth    (depth),
    .flush    (flush),
    .push_req (in_valid),
    .pop_req  (out_ready),
    .push_ok  (push_ok),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .empty    (empty),
    .full     (full),
    .near_full(near_full)
  );

  fdq_store #(.WIDTH(WIDTH), .CAP(CAP)) u_store (
    .clk     (clk),
    .wr_en   (push_ok),
    .wr_addr (wr_addr),
    .wr_data (in_data),
    .rd_addr (rd_addr),
    .rd_blank(empty),
    .rd_data (out_data)
  );

  assign in_ready  = !full;
  assign out_valid = !empty;
endmodule

// File: rtl/frame_depth_fifo_chk.sv
module frame_depth_fifo_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data,
  input logic             full,
  input logic             near_full,
  input logic             empty
);
  // R6: an offer to a full queue that is not drained changes nothing visible.
  p_drop_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && !out_ready && !flush) |=> (full && $stable(out_data)));

  // R7: full implies the one-short flag.
  p_full_has_near_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> near_full);

  // R8: full persists until something is popped.
  p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !out_ready && !flush) |=> full);

  // R9: an accepted word clears empty.
  p_push_clears_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !flush) |=> !empty);

  // R11: without a push, an empty queue stays empty and reads zero.
  p_empty_pop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !in_valid && !flush) |=> (empty && out_data == '0));

  // R12: flush leaves an empty queue with both fill flags low.
  p_flush_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !full && !near_full));
endmodule

bind frame_depth_fifo frame_depth_fifo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush    (flush),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_ready(out_ready),
  .out_data (out_data),
  .full     (full),
  .near_full(near_full),
  .empty    (empty)
);

// File: tb/frame_depth_fifo_bench.sv
`timescale 1ns/1ps
module frame_depth_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic [5:0]  frame_bits = 6'd8;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        full, near_full, empty;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frame_depth_fifo u_frame_depth_fifo (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .frame_bits(frame_bits),
    .flush(flush), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .full(full), .near_full(near_full), .empty(empty)
  );

  // Vector: op[68:67] (1 push, 2 pop, 3 both), din[66:35], head[34:3],
  // empty[2], near_full[1], full[0]. Depth is 4 (wide_mode=0).
  localparam int NV = 12;
  localparam logic [68:0] VECS [NV] = '{
    {2'd1, 32'hA1, 32'hA1, 3'b000},
    {2'd1, 32'hA2, 32'hA1, 3'b000},
    {2'd1, 32'hA3, 32'hA1, 3'b010},  // R7 near at depth-1
    {2'd1, 32'hA4, 32'hA1, 3'b011},  // R8 full at depth
    {2'd1, 32'hA5, 32'hA1, 3'b011},  // R6 dropped offer
    {2'd2, 32'h00, 32'hA2, 3'b010},  // R8 pop clears full
    {2'd3, 32'hA6, 32'hA3, 3'b010},  // R13 push and pop together
    {2'd2, 32'h00, 32'hA4, 3'b000},  // R7 near clears
    {2'd2, 32'h00, 32'hA6, 3'b000},  // R6 A5 never shows
    {2'd2, 32'h00, 32'h00, 3'b100},  // R9 last pop sets empty
    {2'd2, 32'h00, 32'h00, 3'b100},  // R11 pop on empty
    {2'd1, 32'hA7, 32'hA7, 3'b000}   // R11 pointers intact
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic fill(input int exp_depth, input string tag, output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (!in_ready) break;
      in_valid = 1'b1;
      in_data  = 32'h1000 + i;
      @(negedge clk);
      n++;
      if (n == exp_depth - 1)
        check(near_full && !full, {tag, " R7 near_full at depth-1"}, {30'd0, near_full, full}, 32'd2);
    end
    in_valid = 1'b0;
  endtask

  task automatic measure(input logic wm, input logic [5:0] fs, input int exp_depth, input string tag);
    int n;
    do_flush();
    wide_mode  = wm;
    frame_bits = fs;
    @(negedge clk);
    fill(exp_depth, tag, n);
    check(n == exp_depth, {tag, " usable depth"}, n, exp_depth);
    check(full && !in_ready, {tag, " R8 full at depth"}, {31'd0, full}, 32'd1);
    in_valid = 1'b1;
    in_data  = 32'hDEAD;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_data == 32'h1000 && full, {tag, " R6 extra offer dropped"}, out_data, 32'h1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(empty && !full && !near_full && !out_valid && out_data == '0,
          "R1 reset state", {27'd0, empty, full, near_full, out_valid, |out_data}, 32'h10);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VECS[i][68:67];
      in_valid  = op[0];
      out_ready = op[1];
      in_data   = VECS[i][66:35];
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b0;
      check(out_data == VECS[i][34:3], "R10 R6 R11 R13 head word", out_data, VECS[i][34:3]);
      check(empty == VECS[i][2], "R9 empty flag", {31'd0, empty}, {31'd0, VECS[i][2]});
      check(near_full == VECS[i][1], "R7 near_full flag", {31'd0, near_full}, {31'd0, VECS[i][1]});
      check(full == VECS[i][0], "R8 full flag", {31'd0, full}, {31'd0, VECS[i][0]});
    end

    measure(1'b0, 6'd8,  4,  "R2");
    measure(1'b0, 6'd20, 4,  "R2");
    measure(1'b1, 6'd8,  32, "R3");
    measure(1'b1, 6'd1,  32, "R3");
    measure(1'b1, 6'd9,  16, "R4");
    measure(1'b1, 6'd16, 16, "R4");
    measure(1'b1, 6'd17, 8,  "R5");
    measure(1'b1, 6'd32, 8,  "R5");

    // R12: flush wins over a same-cycle push and pop.
    flush = 1'b1; in_valid = 1'b1; out_ready = 1'b1; in_data = 32'h77;
    @(negedge clk);
    flush = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    check(empty && !full && !near_full && out_data == '0, "R12 flush overrides streams",
          out_data, 32'h0);

    // R11: pop on empty, then a push must show next.
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(empty && out_data == '0, "R11 pop on empty ignored", out_data, 32'h0);
    in_valid = 1'b1; in_data = 32'hBEEF;
    @(negedge clk);
    in_valid = 1'b0;
    check(!empty && out_data == 32'hBEEF, "R11 next push is head", out_data, 32'hBEEF);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(empty && out_data == '0, "R9 drain sets empty", out_data, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule